// File: doc/BRIEF.md
# Set/clear clock and reset register bank

This block keeps the reset state and the clock-stop state of up to 64 peripherals in four 32-bit control words. Two words hold the reset bits and two hold the clock-stop bits. Each word has two addresses. A write to the base address turns on every bit that is 1 in the written data. A write to the address 4 bytes higher turns off every bit that is 1 in the data. Bits written as 0 keep their value, so software never needs a read-modify-write sequence.

The register port is synchronous and single-cycle: address, write strobe, write data, and read data. Read data is combinational and is taken from the registered state. The block drives four sets of outputs:

- a reset line for each peripheral;
- a clock enable for each peripheral;
- a combined "peripheral running" flag for each peripheral;
- the baud-reference select for one group of UARTs.

One clock bit works with the opposite polarity from the others: setting it turns its clock on instead of stopping it.

Top module: `clk_rst_regbank`

## Requirements
- R1: After reset, all 64 reset bits are 1. All clock-stop bits are 1 except bit 14, which is 0. As a result, every peripheral is held in reset with its clock off.
- R2: A write to a base offset sets each bit whose written data bit is 1. Bits written as 0 are unchanged. The base offsets are 0x40 for reset bits 0-31, 0x50 for reset bits 32-63, 0x80 for clock bits 0-31 and 0x90 for clock bits 32-63.
- R3: A write to base+4 (0x44, 0x54, 0x84, 0x94) clears each bit whose written data bit is 1. Bits written as 0 are unchanged.
- R4: A read at a base offset returns the 32 bits of that word. A read at base+4 returns the same value.
- R5: `periph_rst[i]` equals reset bit i. Bit i of word 0x40 drives index i, and bit i of word 0x50 drives index 32+i.
- R6: `periph_clk_en[i]` is the inverse of clock bit i for every i except 14. For i = 14, `periph_clk_en[14]` equals the bit itself.
- R7: `periph_on[i]` is 1 only when reset bit i is 0 and `periph_clk_en[i]` is 1.
- R8: `uart_div13_sel` equals bit 31 of word 0x80. A value of 1 selects the divide-by-13 reference.
- R9: Any address outside the eight mapped addresses reads as zero, and a write to it changes no state.
- R10: A read in the same cycle as a write returns the value from before the write. The written value becomes visible at the port and on the outputs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, used as a bit mask |
| rd_data | output | 32 | Read data for `addr` |
| periph_rst | output | 64 | Per-peripheral reset, 1 = held in reset |
| periph_clk_en | output | 64 | Per-peripheral clock enable |
| periph_on | output | 64 | Peripheral out of reset with its clock running |
| uart_div13_sel | output | 1 | Selects the divide-by-13 UART baud reference |

## Verification
A read and a write can fall in the same cycle. This happens because the port carries a single address that serves both purposes.

Every stimulus cycle, random or directed, drives the write strobe while the bench samples `rd_data` before the clock edge. The bench compares that sample with its model's pre-write word. It then compares all outputs after the edge with the post-write model.

Writes to clock word 0x80 that flip bit 31 are also judged on two outputs in the same cycle: the clock enable of peripheral 31 and the UART reference select.

// File: rtl/clk_rst_regbank.sv
module clk_rst_regbank #(
  parameter int AW = 12,
  parameter logic [AW-1:0] RST_LO_OFS  = 12'h040,
  parameter logic [AW-1:0] RST_HI_OFS  = 12'h050,
  parameter logic [AW-1:0] STOP_LO_OFS = 12'h080,
  parameter logic [AW-1:0] STOP_HI_OFS = 12'h090,
  parameter int CLR_STEP  = 4,
  parameter int INV_BIT   = 14,
  parameter int DIV13_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic [63:0]   periph_rst,
  output logic [63:0]   periph_clk_en,
  output logic [63:0]   periph_on,
  output logic          uart_div13_sel
);

  localparam int NW = 4;
  localparam logic [63:0] INV_MASK  = 64'd1 << INV_BIT;
  localparam logic [63:0] STOP_INIT = ~INV_MASK;
  localparam logic [AW-1:0] BASE [NW] = '{RST_LO_OFS, RST_HI_OFS, STOP_LO_OFS, STOP_HI_OFS};
  localparam logic [31:0]   INIT [NW] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          STOP_INIT[31:0], STOP_INIT[63:32]};

  logic [31:0] word_q [NW];
  logic [NW-1:0] rd_hit;

  for (genvar k = 0; k < NW; k++) begin : g_word
    localparam logic [AW-1:0] CLR_OFS = BASE[k] + AW'(CLR_STEP);
    logic hit_set, hit_clr;
    assign hit_set   = wr_en && (addr == BASE[k]);
    assign hit_clr   = wr_en && (addr == CLR_OFS);
    assign rd_hit[k] = (addr == BASE[k]) || (addr == CLR_OFS);

    always_ff @(posedge clk) begin
      if (!rst_n)       word_q[k] <= INIT[k];
      else if (hit_set) word_q[k] <= word_q[k] | wr_data;
      else if (hit_clr) word_q[k] <= word_q[k] & ~wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NW; k++)
      if (rd_hit[k]) rd_data = rd_data | word_q[k];
  end

  logic [63:0] stop_vec;
  assign stop_vec       = {word_q[3], word_q[2]};
  assign periph_rst     = {word_q[1], word_q[0]};
  assign periph_clk_en  = ~stop_vec ^ INV_MASK;
  assign periph_on      = periph_clk_en & ~periph_rst;
  assign uart_div13_sel = stop_vec[DIV13_BIT];

endmodule

// File: rtl/clk_rst_regbank_chk.sv
module clk_rst_regbank_chk #(
  parameter int AW = 12,
  parameter logic [AW-1:0] RST_LO_OFS  = 12'h040,
  parameter logic [AW-1:0] STOP_LO_OFS = 12'h080,
  parameter logic [AW-1:0] STOP_HI_OFS = 12'h090,
  parameter int CLR_STEP  = 4,
  parameter int INV_BIT   = 14,
  parameter int DIV13_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic [31:0]   rd_data,
  input logic [63:0]   periph_rst,
  input logic [63:0]   periph_clk_en,
  input logic          uart_div13_sel
);
  localparam logic [AW-1:0] RST_LO_CLR = RST_LO_OFS + AW'(CLR_STEP);
  localparam int IB  = INV_BIT % 32;
  localparam logic [AW-1:0] IW = (INV_BIT < 32) ? STOP_LO_OFS : STOP_HI_OFS;
  localparam int ORD = (INV_BIT == 0) ? 1 : 0;

  // R2
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RST_LO_OFS) |=>
      periph_rst[31:0] == ($past(periph_rst[31:0]) | $past(wr_data)));

  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RST_LO_CLR) |=>
      periph_rst[31:0] == ($past(periph_rst[31:0]) & ~$past(wr_data)));

  // R4
  clr_alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RST_LO_CLR) |-> rd_data == periph_rst[31:0]);

  // R6
  inverted_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == IW) |-> rd_data[IB] == periph_clk_en[INV_BIT]);

  // R6
  normal_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STOP_LO_OFS) |-> rd_data[ORD] != periph_clk_en[ORD]);

  // R8
  div13_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_div13_sel == !periph_clk_en[DIV13_BIT]);

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data == 32'd0 && addr != RST_LO_OFS && addr != RST_LO_CLR &&
     addr[AW-1:4] != RST_LO_OFS[AW-1:4] + 1'b1 && addr[AW-1:4] != STOP_LO_OFS[AW-1:4] &&
     addr[AW-1:4] != STOP_HI_OFS[AW-1:4])
      |=> $stable(periph_rst) && $stable(periph_clk_en));
endmodule

bind clk_rst_regbank clk_rst_regbank_chk #(
  .AW(AW), .RST_LO_OFS(RST_LO_OFS), .STOP_LO_OFS(STOP_LO_OFS),
  .STOP_HI_OFS(STOP_HI_OFS), .CLR_STEP(CLR_STEP), .INV_BIT(INV_BIT),
  .DIV13_BIT(DIV13_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .periph_rst(periph_rst), .periph_clk_en(periph_clk_en),
  .uart_div13_sel(uart_div13_sel)
);

// File: tb/sim_clk_rst_regbank.sv
`timescale 1ns/1ps
module sim_clk_rst_regbank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] periph_rst, periph_clk_en, periph_on;
  logic        uart_div13_sel;

  int checks = 0, errors = 0;
  logic [63:0] m_rst, m_stop;

  clk_rst_regbank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .periph_rst(periph_rst), .periph_clk_en(periph_clk_en),
    .periph_on(periph_on), .uart_div13_sel(uart_div13_sel));

  always #4 clk = ~clk;

  function automatic logic [31:0] exp_read(logic [11:0] a);
    case (a)
      12'h040, 12'h044: return m_rst[31:0];
      12'h050, 12'h054: return m_rst[63:32];
      12'h080, 12'h084: return m_stop[31:0];
      12'h090, 12'h094: return m_stop[63:32];
      default:          return 32'd0;
    endcase
  endfunction

  function automatic logic [63:0] exp_en();
    return ~m_stop ^ (64'd1 << 14);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(string tag);
    chk({tag, " R5 periph_rst"}, periph_rst, m_rst);
    chk({tag, " R6 periph_clk_en"}, periph_clk_en, exp_en());
    chk({tag, " R7 periph_on"}, periph_on, exp_en() & ~m_rst);
    chk({tag, " R8 uart_div13_sel"}, 64'(uart_div13_sel), 64'(m_stop[31]));
  endtask

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    case (a)
      12'h040: m_rst[31:0]   |= d;   12'h044: m_rst[31:0]   &= ~d;
      12'h050: m_rst[63:32]  |= d;   12'h054: m_rst[63:32]  &= ~d;
      12'h080: m_stop[31:0]  |= d;   12'h084: m_stop[31:0]  &= ~d;
      12'h090: m_stop[63:32] |= d;   12'h094: m_stop[63:32] &= ~d;
      default: ;
    endcase
  endtask

  // Drive one access; R4/R10: read before edge shows pre-write value; R2/R3/R9 after.
  task automatic op(logic [11:0] a, logic we, logic [31:0] d, string tag);
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d;
    #1;
    chk({tag, " R4 R10 read"}, 64'(rd_data), 64'(exp_read(a)));
    @(posedge clk);
    if (we) model_write(a, d);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk({tag, " R2 R3 R9 readback"}, 64'(rd_data), 64'(exp_read(a)));
    chk_outputs(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [11:0] MAP [8] = '{12'h040, 12'h044, 12'h050, 12'h054,
                                      12'h080, 12'h084, 12'h090, 12'h094};

  initial begin
    void'($urandom(32'h5EED_0C1C));
    m_rst  = '1;
    m_stop = ~(64'd1 << 14);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 periph_rst", periph_rst, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 stop word", 64'(rd_data), 64'd0);
    chk("R1 periph_on", periph_on, 64'd0);
    chk("R1 periph_clk_en", periph_clk_en, 64'd0);
    op(12'h080, 0, 0, "R1 stop read");

    // Directed
    op(12'h054, 1, 32'h0000_0001, "R3 clear rst bit 32");
    op(12'h044, 1, 32'h0000_0000, "R3 zero mask no change");
    op(12'h084, 1, 32'h0000_0003, "R6 start clocks 0,1");
    op(12'h044, 1, 32'h0000_0001, "R7 release rst 0");
    op(12'h080, 1, 32'h0000_4000, "R6 inverted bit 14 set enables");
    op(12'h044, 1, 32'h0000_4000, "R7 periph 14 on");
    op(12'h084, 1, 32'h8000_0000, "R8 div13 off");
    op(12'h080, 1, 32'h8000_0000, "R8 div13 on");
    op(12'h040, 1, 32'h0000_0000, "R2 zero mask no change");
    op(12'h048, 1, 32'hFFFF_FFFF, "R9 unmapped 0x48");
    op(12'h098, 1, 32'hFFFF_FFFF, "R9 unmapped 0x98");
    op(12'h100, 1, 32'hFFFF_FFFF, "R9 unmapped 0x100");
    op(12'h042, 1, 32'hFFFF_FFFF, "R9 unaligned 0x42");

    // Random
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      if ($urandom % 8 == 0) a = 12'($urandom);
      else a = MAP[$urandom % 8];
      d = $urandom;
      op(a, ($urandom % 4) != 0, d, "rand R2 R3 R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule